// File: doc/BRIEF.md
# Label-Pair Verdict Cache

This block caches the outcome of earlier information-flow checks. Each check is keyed by two global 16-bit security labels. One is the label of the hardware thread that makes the access. The other is the label carried with the cache line being accessed. The block holds one label register for each hardware thread, and a write port updates them.

Every memory access presents a thread ID and a data label. The block picks that thread's label and searches all entries for the pair. It answers allow, deny or miss. The pipeline commits the instruction only on allow. A miss is a trap request to a software handler. The handler later decides the verdict and writes it back through the fill port. The hardware never makes a policy decision itself.

Requests use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The response appears in the next cycle and stays stable until it is consumed with `rsp_ready`. `req_ready` is high whenever no response is pending, or the pending one is being consumed in the same cycle. The fill, flush and label-write ports have no handshake and are always taken.

Top module: `flow_verdict_cache`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1. Both thread label registers hold 0, and every lookup misses.
- R2: A request accepted at a clock edge gives `rsp_valid`=1 after that edge. On a hit, `rsp_result` is 2'b00 for an allow verdict and 2'b01 for a deny verdict.
- R3: On a miss, `rsp_result` is 2'b10 (trap request). `rsp_tlabel` and `rsp_dlabel` give the label pair that missed. The code 2'b11 never appears.
- R4: The key is the full pair. A stored pair hits only when the selected thread label and the data label both match. `req_tid` 0 and 1 select the two thread label registers.
- R5: A fill whose pair is already cached rewrites that entry's verdict in place. It uses no new slot, so no other entry is lost.
- R6: A fill of a new pair takes a slot in strict round-robin order over the 16 slots. Once all slots are full, each new pair evicts the pair that was allocated longest ago.
- R7: `flush` invalidates every entry in one cycle and restarts the round-robin order at slot 0. A lookup accepted in the flush cycle sees an empty cache.
- R8: A lookup accepted in the same cycle as a fill of the same pair returns the verdict being filled.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and the response outputs keep their values.
- R10: A label register write applies to lookups accepted after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lbl_we | input | 1 | Write a thread label register |
| lbl_tid | input | 1 | Thread whose label is written |
| lbl_wdata | input | 16 | New thread label |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_tid | input | 1 | Thread ID of the access |
| req_dlabel | input | 16 | Label of the accessed line |
| rsp_valid | output | 1 | Verdict available |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_result | output | 2 | 00 allow, 01 deny, 10 miss/trap |
| rsp_tlabel | output | 16 | Thread label used for the lookup |
| rsp_dlabel | output | 16 | Data label used for the lookup |
| fill_valid | input | 1 | Install a verdict |
| fill_tlabel | input | 16 | Thread label of the installed pair |
| fill_dlabel | input | 16 | Data label of the installed pair |
| fill_allow | input | 1 | 1 = allow, 0 = deny |

## Verification
A corrupted entry or label register shows up on the next lookup of the affected pair, one cycle after acceptance. It appears as a wrong verdict or a miss where a hit was expected, and a miss also shows the wrong labels on `rsp_tlabel`. A broken in-place rewrite or a skewed round-robin pointer hides until the slots wrap. It then surfaces as a miss on the wrong victim pair. The bench therefore fills all slots, rewrites one and allocates past the wrap. It then sweeps every cached pair. A failed flush is visible on the first lookup after the flush cycle.

// File: rtl/flow_verdict_pkg.sv
package flow_verdict_pkg;
  typedef enum logic [1:0] {
    RES_ALLOW = 2'b00,
    RES_DENY  = 2'b01,
    RES_MISS  = 2'b10
  } fv_result_e;
endpackage

// File: rtl/fvc_label_regs.sv
module fvc_label_regs #(
  parameter int THREADS = 2,
  parameter int LBL_W   = 16,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [TID_W-1:0] wr_tid,
  input  logic [LBL_W-1:0] wr_label,
  input  logic [TID_W-1:0] rd_tid,
  output logic [LBL_W-1:0] rd_label
);
  logic [LBL_W-1:0] lbl_q [THREADS];

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lbl_q[t] <= '0;
      end else if (we && (int'(wr_tid) == t)) begin
        lbl_q[t] <= wr_label;
      end
    end
  end

  always_comb begin
    rd_label = '0;
    for (int t = 0; t < THREADS; t++) begin
      if (int'(rd_tid) == t) rd_label = lbl_q[t];
    end
  end
endmodule

// File: rtl/fvc_rr_victim.sv
module fvc_rr_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (flush) begin
      ptr <= alloc ? IDX_W'(1) : '0;
    end else if (alloc) begin
      ptr <= ptr + IDX_W'(1);
    end
  end
endmodule

// File: rtl/fvc_pair_array.sv
module fvc_pair_array #(
  parameter int ENTRIES = 16,
  parameter int LBL_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fill_valid,
  input  logic [LBL_W-1:0] fill_tlabel,
  input  logic [LBL_W-1:0] fill_dlabel,
  input  logic             fill_allow,
  input  logic [IDX_W-1:0] victim,
  output logic             alloc,
  input  logic [LBL_W-1:0] lk_tlabel,
  input  logic [LBL_W-1:0] lk_dlabel,
  output logic             lk_hit,
  output logic             lk_allow
);
  logic             vld_q   [ENTRIES];
  logic [LBL_W-1:0] tl_q    [ENTRIES];
  logic [LBL_W-1:0] dl_q    [ENTRIES];
  logic             allow_q [ENTRIES];

  logic [ENTRIES-1:0] fill_match, lk_match;
  logic               fill_hit_any;
  logic [IDX_W-1:0]   wr_idx;
  logic               arr_hit, arr_allow, byp_hit;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign fill_match[e] = vld_q[e] && !flush &&
                           (tl_q[e] == fill_tlabel) && (dl_q[e] == fill_dlabel);
    assign lk_match[e]   = vld_q[e] && !flush &&
                           (tl_q[e] == lk_tlabel) && (dl_q[e] == lk_dlabel);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[e]   <= 1'b0;
        tl_q[e]    <= '0;
        dl_q[e]    <= '0;
        allow_q[e] <= 1'b0;
      end else begin
        if (flush) vld_q[e] <= 1'b0;
        if (fill_valid && (int'(wr_idx) == e) && (alloc || fill_match[e])) begin
          vld_q[e]   <= 1'b1;
          tl_q[e]    <= fill_tlabel;
          dl_q[e]    <= fill_dlabel;
          allow_q[e] <= fill_allow;
        end
      end
    end
  end

  assign fill_hit_any = |fill_match;
  assign alloc        = fill_valid && !fill_hit_any;

  always_comb begin
    wr_idx = flush ? '0 : victim;
    for (int e = 0; e < ENTRIES; e++) begin
      if (fill_match[e]) wr_idx = IDX_W'(e);
    end
  end

  always_comb begin
    arr_hit   = |lk_match;
    arr_allow = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      arr_allow = arr_allow | (lk_match[e] & allow_q[e]);
    end
  end

  assign byp_hit  = fill_valid && (fill_tlabel == lk_tlabel) && (fill_dlabel == lk_dlabel);
  assign lk_hit   = byp_hit || arr_hit;
  assign lk_allow = byp_hit ? fill_allow : arr_allow;
endmodule

// File: rtl/flow_verdict_cache.sv
module flow_verdict_cache
  import flow_verdict_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int LBL_W   = 16,
  parameter int THREADS = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lbl_we,
  input  logic [TID_W-1:0] lbl_tid,
  input  logic [LBL_W-1:0] lbl_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [TID_W-1:0] req_tid,
  input  logic [LBL_W-1:0] req_dlabel,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_result,
  output logic [LBL_W-1:0] rsp_tlabel,
  output logic [LBL_W-1:0] rsp_dlabel,
  input  logic             fill_valid,
  input  logic [LBL_W-1:0] fill_tlabel,
  input  logic [LBL_W-1:0] fill_dlabel,
  input  logic             fill_allow
);
  logic [LBL_W-1:0] lk_tlabel;
  logic [IDX_W-1:0] victim;
  logic             alloc, lk_hit, lk_allow, accept;
  fv_result_e       lk_res;

  fvc_label_regs #(.THREADS(THREADS), .LBL_W(LBL_W)) lbl_i (
    .clk(clk), .rst_n(rst_n), .we(lbl_we), .wr_tid(lbl_tid), .wr_label(lbl_wdata),
    .rd_tid(req_tid), .rd_label(lk_tlabel)
  );

  fvc_rr_victim #(.ENTRIES(ENTRIES)) rr_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .alloc(alloc), .ptr(victim)
  );

  fvc_pair_array #(.ENTRIES(ENTRIES), .LBL_W(LBL_W)) arr_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fill_valid(fill_valid), .fill_tlabel(fill_tlabel), .fill_dlabel(fill_dlabel),
    .fill_allow(fill_allow), .victim(victim), .alloc(alloc),
    .lk_tlabel(lk_tlabel), .lk_dlabel(req_dlabel), .lk_hit(lk_hit), .lk_allow(lk_allow)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign lk_res    = !lk_hit ? RES_MISS : (lk_allow ? RES_ALLOW : RES_DENY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_result <= RES_MISS;
      rsp_tlabel <= '0;
      rsp_dlabel <= '0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_result <= lk_res;
      rsp_tlabel <= lk_tlabel;
      rsp_dlabel <= req_dlabel;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/flow_verdict_cache_chk.sv
module flow_verdict_cache_chk #(
  parameter int LBL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LBL_W-1:0] req_dlabel,
  input logic [LBL_W-1:0] lk_tlabel,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [1:0]       rsp_result,
  input logic [LBL_W-1:0] rsp_tlabel,
  input logic             fill_valid,
  input logic [LBL_W-1:0] fill_tlabel,
  input logic [LBL_W-1:0] fill_dlabel,
  input logic             fill_allow
);
  // R2
  accept_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R3
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_result != 2'b11));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_result) && $stable(rsp_tlabel)));

  // R7
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && req_valid && req_ready && !fill_valid) |=> (rsp_result == 2'b10));

  // R8
  fill_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && fill_valid && fill_tlabel == lk_tlabel &&
     fill_dlabel == req_dlabel) |=> (rsp_result == {1'b0, !$past(fill_allow)}));
endmodule

bind flow_verdict_cache flow_verdict_cache_chk #(.LBL_W(LBL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_ready(req_ready),
  .req_dlabel(req_dlabel), .lk_tlabel(lk_tlabel), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_result(rsp_result), .rsp_tlabel(rsp_tlabel),
  .fill_valid(fill_valid), .fill_tlabel(fill_tlabel), .fill_dlabel(fill_dlabel),
  .fill_allow(fill_allow)
);

// File: tb/flow_verdict_cache_tb.sv
module flow_verdict_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0, lbl_we = 1'b0, lbl_tid = 1'b0;
  logic [15:0] lbl_wdata = '0;
  logic        req_valid = 1'b0, req_tid = 1'b0, rsp_ready = 1'b1;
  logic [15:0] req_dlabel = '0;
  logic        req_ready, rsp_valid;
  logic [1:0]  rsp_result;
  logic [15:0] rsp_tlabel, rsp_dlabel;
  logic        fill_valid = 1'b0, fill_allow = 1'b0;
  logic [15:0] fill_tlabel = '0, fill_dlabel = '0;

  int errors = 0, checks = 0;
  bit done = 0;
  bit vexp [16];

  localparam logic [15:0] LA = 16'h1234, LB = 16'hBEEF;

  always #2 clk = ~clk;

  flow_verdict_cache dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lbl_we(lbl_we), .lbl_tid(lbl_tid),
    .lbl_wdata(lbl_wdata), .req_valid(req_valid), .req_ready(req_ready), .req_tid(req_tid),
    .req_dlabel(req_dlabel), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_result(rsp_result), .rsp_tlabel(rsp_tlabel), .rsp_dlabel(rsp_dlabel),
    .fill_valid(fill_valid), .fill_tlabel(fill_tlabel), .fill_dlabel(fill_dlabel),
    .fill_allow(fill_allow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] code(input bit allow);
    return allow ? 2'b00 : 2'b01;
  endfunction

  task automatic set_label(input logic tid, input logic [15:0] v);
    @(negedge clk); lbl_we = 1; lbl_tid = tid; lbl_wdata = v;
    @(negedge clk); lbl_we = 0;
  endtask

  task automatic fill(input logic [15:0] t, input logic [15:0] d, input bit a);
    @(negedge clk); fill_valid = 1; fill_tlabel = t; fill_dlabel = d; fill_allow = a;
    @(negedge clk); fill_valid = 0;
  endtask

  task automatic look(input string req, input logic tid, input logic [15:0] d,
                      input logic [1:0] exp);
    @(negedge clk); req_valid = 1; req_tid = tid; req_dlabel = d;
    @(negedge clk); req_valid = 0;
    chk(req, {31'd0, rsp_valid}, 32'd1);
    chk(req, {30'd0, rsp_result}, {30'd0, exp});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    look("R1 empty miss", 0, 16'h0100, 2'b10);
    chk("R1 label zero", {16'd0, rsp_tlabel}, 32'd0);

    set_label(0, LA);
    set_label(1, LB);

    // R2 fill all slots then sweep
    for (int i = 0; i < 16; i++) begin
      vexp[i] = (i % 3) != 0;
      fill(LA, 16'h0100 + 16'(i), vexp[i]);
    end
    for (int i = 0; i < 16; i++) look("R2 hit", 0, 16'h0100 + 16'(i), code(vexp[i]));

    // R4 / R3: other thread label misses, reports the pair
    for (int i = 0; i < 16; i++) begin
      look("R4 pair key", 1, 16'h0100 + 16'(i), 2'b10);
      chk("R3 trap tlabel", {16'd0, rsp_tlabel}, {16'd0, LB});
      chk("R3 trap dlabel", {16'd0, rsp_dlabel}, {16'd0, 16'h0100 + 16'(i)});
    end

    // R5 overwrite in place
    vexp[5] = !vexp[5];
    fill(LA, 16'h0105, vexp[5]);
    for (int i = 0; i < 16; i++) look("R5 in place", 0, 16'h0100 + 16'(i), code(vexp[i]));

    // R6 round-robin eviction
    fill(LA, 16'h0200, 1'b1);
    look("R6 evict first", 0, 16'h0100, 2'b10);
    look("R6 new hit", 0, 16'h0200, 2'b00);
    fill(LA, 16'h0201, 1'b0);
    look("R6 evict second", 0, 16'h0101, 2'b10);
    look("R6 new deny", 0, 16'h0201, 2'b01);
    for (int i = 2; i < 16; i++) look("R6 survivors", 0, 16'h0100 + 16'(i), code(vexp[i]));

    // R8 same-cycle fill bypass (allocates slot 2)
    @(negedge clk);
    fill_valid = 1; fill_tlabel = LA; fill_dlabel = 16'h0300; fill_allow = 1;
    req_valid = 1; req_tid = 0; req_dlabel = 16'h0300;
    @(negedge clk); fill_valid = 0; req_valid = 0;
    chk("R8 bypass", {30'd0, rsp_result}, 32'd0);
    look("R6 evict third", 0, 16'h0102, 2'b10);

    // R9 back-pressure
    @(negedge clk); rsp_ready = 0; req_valid = 1; req_tid = 0; req_dlabel = 16'h0103;
    @(negedge clk); req_dlabel = 16'h0104;
    chk("R9 first rsp", {30'd0, rsp_result}, {30'd0, code(vexp[3])});
    for (int k = 0; k < 3; k++) begin
      chk("R9 ready low", {31'd0, req_ready}, 32'd0);
      chk("R9 held", {30'd0, rsp_result}, {30'd0, code(vexp[3])});
      chk("R9 held dlabel", {16'd0, rsp_dlabel}, 32'h0103);
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk); req_valid = 0;
    chk("R9 next rsp", {30'd0, rsp_result}, {30'd0, code(vexp[4])});
    chk("R9 next dlabel", {16'd0, rsp_dlabel}, 32'h0104);

    // R10 label write applies afterwards
    look("R10 before", 1, 16'h010F, 2'b10);
    set_label(1, LA);
    look("R10 after", 1, 16'h010F, code(vexp[15]));
    chk("R10 tlabel", {16'd0, rsp_tlabel}, {16'd0, LA});

    // R7 flush with a lookup in the same cycle
    @(negedge clk); flush = 1; req_valid = 1; req_tid = 0; req_dlabel = 16'h0110 - 16'd1;
    @(negedge clk); flush = 0; req_valid = 0;
    chk("R7 flush cycle", {30'd0, rsp_result}, 32'd2);
    for (int i = 3; i < 16; i++) look("R7 flushed", 0, 16'h0100 + 16'(i), 2'b10);
    look("R7 flushed new", 0, 16'h0200, 2'b10);
    // R7 order restarts at slot 0: 17 fills, first one evicted
    for (int i = 0; i < 17; i++) fill(LB, 16'h0400 + 16'(i), 1'b1);
    look("R7 restart evict", 0, 16'h0400, 2'b10);
    set_label(0, LB);
    look("R7 restart evict lb", 0, 16'h0400, 2'b10);
    look("R7 restart keep", 0, 16'h0401, 2'b00);
    look("R7 restart last", 0, 16'h0410, 2'b00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule